// File: doc/BRIEF.md
# Quadratic Two-Variable Spiking Neuron

This block is a single spiking neuron held in signed fixed point. On every clock with the step enable high it takes one forward-Euler step of width 1/16 of the quadratic membrane equation and of the linear recovery equation, driven by an unsigned 8-bit stimulus current. When the stored membrane value has reached the firing level, that step does not integrate: it snaps the membrane back to its after-fire value, adds a fixed bump to the recovery variable, and raises a one-clock spike pulse.

The membrane value `v` and the recovery value `u` are 16-bit signed numbers with 8 fractional bits, so one LSB is 1/256. All products use 64-bit intermediates, and each new register value is clamped into the 16-bit signed range before it is written. An 8-bit view of the membrane is exported for observation. The default constants give a regular-spiking cell: recovery time scale 0.02, sensitivity 0.2, after-fire membrane -65, recovery bump 8 and firing level 30. Each one is an elaboration parameter.

Top module: `izh_neuron`

## Requirements
- R1: While `rst_n` is low, `v` holds -16640 (-65.0), `u` holds -3328 (-13.0), `spike` is 0 and `state_out` is 63. These values are still present on the first clock after release.
- R2: `state_out` equals floor(v/256)+128, clamped into 0..255.
- R3: On an enabled step with v < 7680, the new v is sat16(v + (dv >>> 4)). Here dv = ((((v*v) >>> 8) * 2621) >>> 16) + 5*v + 35840 - u + 256*cur_in, and every `>>>` is a floor shift.
- R4: On the same kind of step, the new u is sat16(u + ((((v*13107) >>> 16) - u) * 1311 + 524288) >>> 20).
- R5: On an enabled step with v >= 7680 (30.0), v becomes -16640, u becomes sat16(u + 2048), and `spike` is 1 for exactly the following clock.
- R6: Every value written to v or u is clamped into -32768..32767. Under the maximum current of 255, held for 1500 steps, `state_out` never reaches 255 and follows R2 to R5 exactly.
- R7: With `step_en` low, v and u hold, `spike` is 0 and `cur_in` has no effect. A later enabled step continues from the held state.
- R8: From reset, a constant current of 0 or 1 produces no spike in 1500 steps. A constant current of 16 or more produces at least one spike in 1500 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the neuron by one Euler step on this edge |
| cur_in | input | 8 | Unsigned stimulus current, integer units |
| state_out | output | 8 | Integer part of the membrane value plus 128, clamped |
| spike | output | 1 | One-clock pulse after a firing step |

## Verification
The checker assumes that reset is held low for at least one clock edge before it is released. It also assumes that the default parameters are in use, so the after-fire view code is 63 and the firing dynamics keep the membrane well under +127. The stimulus meets both conditions. Every run starts from a reset held low for four edges. Currents are swept from 0 to 255, which covers the whole legal input range including the maximum. `step_en` is dropped only between otherwise normal steps.

// File: rtl/izh_pkg.sv
package izh_pkg;

   // Clamp a wide signed value into a w-bit signed range.
   function automatic logic signed [63:0] clamp_s(input logic signed [63:0] x,
                                                  input int unsigned w);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -(64'sd1 <<< (w - 1));
      if (x > hi)      clamp_s = hi;
      else if (x < lo) clamp_s = lo;
      else             clamp_s = x;
   endfunction

   // Clamp a wide signed value into 0..2^w-1.
   function automatic logic signed [63:0] clamp_u(input logic signed [63:0] x,
                                                  input int unsigned w);
      logic signed [63:0] hi;
      hi = (64'sd1 <<< w) - 64'sd1;
      if (x > hi)        clamp_u = hi;
      else if (x < 64'sd0) clamp_u = 64'sd0;
      else               clamp_u = x;
   endfunction

endpackage

// File: rtl/izh_membrane.sv
module izh_membrane #(
   parameter int W       = 16,
   parameter int FRAC    = 8,
   parameter int IN_W    = 8,
   parameter int DT_SH   = 4,
   parameter int COEF_SH = 16,
   parameter int K_SQ    = 2621,
   parameter int LIN_MUL = 5,
   parameter int BIAS    = 140
) (
   input  logic signed [W-1:0] v,
   input  logic signed [W-1:0] u,
   input  logic [IN_W-1:0]     cur,
   output logic signed [W-1:0] v_upd
);
   import izh_pkg::*;

   localparam logic signed [63:0] BIAS_Q = 64'sd1 * BIAS * (2 ** FRAC);

   logic signed [63:0] vx, ux, ix;
   logic signed [63:0] sq, quad, dv, sum, lim;

   always_comb begin
      vx   = 64'(v);
      ux   = 64'(u);
      ix   = 64'(cur) <<< FRAC;
      sq   = (vx * vx) >>> FRAC;
      quad = (sq * 64'(K_SQ)) >>> COEF_SH;
      dv   = quad + vx * 64'(LIN_MUL) + BIAS_Q - ux + ix;
      sum  = vx + (dv >>> DT_SH);
      lim  = clamp_s(sum, W);
      v_upd = lim[W-1:0];
   end
endmodule

// File: rtl/izh_recovery.sv
module izh_recovery #(
   parameter int W       = 16,
   parameter int DT_SH   = 4,
   parameter int COEF_SH = 16,
   parameter int K_A     = 1311,
   parameter int K_B     = 13107
) (
   input  logic signed [W-1:0] v,
   input  logic signed [W-1:0] u,
   output logic signed [W-1:0] u_upd
);
   import izh_pkg::*;

   localparam int TOT_SH = COEF_SH + DT_SH;
   localparam logic signed [63:0] HALF = 64'sd1 <<< (TOT_SH - 1);

   logic signed [63:0] vx, ux, bv, gap, du, lim;

   always_comb begin
      vx  = 64'(v);
      ux  = 64'(u);
      bv  = (vx * 64'(K_B)) >>> COEF_SH;
      gap = bv - ux;
      du  = (gap * 64'(K_A) + HALF) >>> TOT_SH;
      lim = clamp_s(ux + du, W);
      u_upd = lim[W-1:0];
   end
endmodule

// File: rtl/izh_view.sv
module izh_view #(
   parameter int IW        = 8,
   parameter int OUT_W     = 8,
   parameter bit OFFSET_EN = 1'b1
) (
   input  logic signed [IW-1:0] v_int,
   output logic [OUT_W-1:0]     view
);
   import izh_pkg::*;

   logic signed [63:0] shifted, lim;

   generate
      if (OFFSET_EN) begin : g_offset
         always_comb shifted = 64'(v_int) + (64'sd1 <<< (OUT_W - 1));
      end else begin : g_clamp
         always_comb shifted = 64'(v_int);
      end
   endgenerate

   always_comb begin
      lim  = clamp_u(shifted, OUT_W);
      view = lim[OUT_W-1:0];
   end
endmodule

// File: rtl/izh_neuron.sv
module izh_neuron #(
   parameter int  W           = 16,
   parameter int  FRAC        = 8,
   parameter int  IN_W        = 8,
   parameter int  OUT_W       = 8,
   parameter int  DT_SH       = 4,
   parameter int  COEF_SH     = 16,
   parameter real A_COEF      = 0.02,
   parameter real B_COEF      = 0.2,
   parameter real SQ_COEF     = 0.04,
   parameter int  V_AFTER_INT = -65,
   parameter int  U_BUMP_INT  = 8,
   parameter int  V_PEAK_INT  = 30,
   parameter int  U_INIT_INT  = -13,
   parameter bit  OFFSET_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  logic [IN_W-1:0] cur_in,
   output logic [OUT_W-1:0] state_out,
   output logic            spike
);
   import izh_pkg::*;

   localparam int IW   = W - FRAC;
   localparam int SCL  = 2 ** FRAC;
   localparam int K_A  = $rtoi(A_COEF  * (2.0 ** COEF_SH) + 0.5);
   localparam int K_B  = $rtoi(B_COEF  * (2.0 ** COEF_SH) + 0.5);
   localparam int K_SQ = $rtoi(SQ_COEF * (2.0 ** COEF_SH) + 0.5);
   localparam logic signed [W-1:0] V_AFTER = W'(V_AFTER_INT * SCL);
   localparam logic signed [W-1:0] V_PEAK  = W'(V_PEAK_INT * SCL);
   localparam logic signed [W-1:0] U_INIT  = W'(U_INIT_INT * SCL);
   localparam logic signed [63:0]  U_BUMP  = 64'sd1 * U_BUMP_INT * SCL;

   // Elaboration-time parameter checks
   generate
      if (IW < 8) begin : g_bad_int
         $error("izh_neuron: W-FRAC must leave at least 8 integer bits");
      end
      if (2 * W + COEF_SH + 4 > 64) begin : g_bad_wide
         $error("izh_neuron: products do not fit 64-bit intermediates");
      end
      if (OUT_W > IW) begin : g_bad_out
         $error("izh_neuron: OUT_W exceeds integer bits of v");
      end
      if (DT_SH < 1) begin : g_bad_dt
         $error("izh_neuron: DT_SH must be at least 1");
      end
   endgenerate

   logic signed [W-1:0] v_q, u_q;
   logic signed [W-1:0] v_nx, u_nx;
   logic signed [63:0]  u_bumped;
   logic                fire;

   izh_membrane #(
      .W(W), .FRAC(FRAC), .IN_W(IN_W), .DT_SH(DT_SH), .COEF_SH(COEF_SH),
      .K_SQ(K_SQ), .LIN_MUL(5), .BIAS(140)
   ) u_mem (
      .v(v_q), .u(u_q), .cur(cur_in), .v_upd(v_nx)
   );

   izh_recovery #(
      .W(W), .DT_SH(DT_SH), .COEF_SH(COEF_SH), .K_A(K_A), .K_B(K_B)
   ) u_rec (
      .v(v_q), .u(u_q), .u_upd(u_nx)
   );

   izh_view #(
      .IW(IW), .OUT_W(OUT_W), .OFFSET_EN(OFFSET_EN)
   ) u_view (
      .v_int(v_q[W-1:FRAC]), .view(state_out)
   );

   always_comb begin
      fire     = (v_q >= V_PEAK);
      u_bumped = clamp_s(64'(u_q) + U_BUMP, W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= V_AFTER;
         u_q   <= U_INIT;
         spike <= 1'b0;
      end else if (step_en) begin
         if (fire) begin
            v_q   <= V_AFTER;
            u_q   <= u_bumped[W-1:0];
            spike <= 1'b1;
         end else begin
            v_q   <= v_nx;
            u_q   <= u_nx;
            spike <= 1'b0;
         end
      end else begin
         spike <= 1'b0;
      end
   end
endmodule

// File: rtl/izh_neuron_chk.sv
module izh_neuron_chk #(
   parameter int OUT_W       = 8,
   parameter int V_AFTER_INT = -65
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_en,
   input logic [OUT_W-1:0] state_out,
   input logic             spike
);
   localparam logic [OUT_W-1:0] REST_CODE = OUT_W'(V_AFTER_INT + 2 ** (OUT_W - 1));
   localparam logic [OUT_W-1:0] TOP_CODE  = '1;

   // R1: the state seen at reset release is the resting state
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (state_out == REST_CODE && !spike));

   // R5: a spike lasts one clock only
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      spike |=> !spike);

   // R5: while spiking, the membrane already shows its after-fire value
   a_r5_after_fire_view: assert property (@(posedge clk) disable iff (!rst_n)
      spike |-> state_out == REST_CODE);

   // R7: no step, no change of the view and no spike
   a_r7_hold_view: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(state_out));

   a_r7_idle_no_spike: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> !spike);

   // R6: the membrane never runs up to the top of its range
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      state_out != TOP_CODE);
endmodule

bind izh_neuron izh_neuron_chk u_chk (
   .clk(clk), .rst_n(rst_n), .step_en(step_en),
   .state_out(state_out), .spike(spike)
);

// File: tb/izh_neuron_bench.sv
module izh_neuron_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_en = 1'b0;
   logic [7:0] cur_in = 8'd0;
   logic [7:0] state_out;
   logic       spike;

   int total = 0;
   int bad   = 0;

   longint mv, mu;
   bit     mspk;

   always #2.5 clk = ~clk;

   izh_neuron u_izh_neuron (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .cur_in(cur_in),
      .state_out(state_out), .spike(spike)
   );

   function automatic longint sat16(input longint x);
      if (x > 32767)  return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   function automatic int view_of(input longint v);
      longint t;
      t = (v >>> 8) + 128;
      if (t < 0)   t = 0;
      if (t > 255) t = 255;
      return int'(t);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(input int i);
      longint dv, bv, nv, nu;
      if (mv >= 7680) begin
         mv   = -16640;
         mu   = sat16(mu + 2048);
         mspk = 1'b1;
      end else begin
         dv   = ((((mv * mv) >>> 8) * 2621) >>> 16) + 5 * mv + 35840 - mu + 256 * longint'(i);
         nv   = sat16(mv + (dv >>> 4));
         bv   = (mv * 13107) >>> 16;
         nu   = sat16(mu + (((bv - mu) * 1311 + 524288) >>> 20));
         mv   = nv;
         mu   = nu;
         mspk = 1'b0;
      end
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      step_en = 1'b0;
      repeat (4) @(negedge clk);
      check("R1 reset view", int'(state_out), 63);
      check("R1 reset spike", int'(spike), 0);
      rst_n = 1'b1;
      mv = -16640; mu = -3328; mspk = 1'b0;
      @(negedge clk);
      check("R1 view after release", int'(state_out), 63);
   endtask

   // Run with a constant current, compare every step, return spike count and peak view
   task automatic run_steps(input int i, input int n, output int nspk, output int peak);
      nspk = 0;
      peak = 0;
      cur_in  = 8'(i);
      step_en = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         model_step(i);
         @(negedge clk);
         check("R2/R3/R4 state", int'(state_out), view_of(mv));
         check("R5 spike", int'(spike), int'(mspk));
         if (spike) nspk++;
         if (int'(state_out) > peak) peak = int'(state_out);
      end
      step_en = 1'b0;
   endtask

   initial begin
      int nspk, peak, held;
      do_reset();

      // R8, R3, R4, R5, R6: sweep of constant currents
      for (int i = 0; i < 256; i = (i < 16) ? i + 1 : ((i == 240) ? 255 : i + 16)) begin
         do_reset();
         run_steps(i, 1500, nspk, peak);
         if (i <= 1)  check("R8 no spike below threshold", nspk, 0);
         if (i >= 16) check("R8 spikes above threshold", int'(nspk > 0), 1);
         if (i == 255) begin
            check("R6 view below top under max current", int'(peak < 255), 1);
            check("R6 fired under max current", int'(nspk > 0), 1);
         end
         if (i == 255) break;
      end

      // R7: pause mid-run, wiggle the current, resume from the held state
      do_reset();
      run_steps(40, 37, nspk, peak);
      held = int'(state_out);
      for (int k = 0; k < 20; k++) begin
         cur_in = (k % 2 == 0) ? 8'd255 : 8'd0;
         @(negedge clk);
         check("R7 view held", int'(state_out), held);
         check("R7 no spike while idle", int'(spike), 0);
      end
      run_steps(40, 300, nspk, peak);
      check("R7 resumed run fired", int'(nspk > 0), 1);

      // R1: reset in the middle of activity
      run_steps(255, 5, nspk, peak);
      do_reset();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(750000.0);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule